// File: doc/BRIEF.md
# Bus Pin Hold and Reset Controller

This block sits between a 32-bit processor core and its external bus pins and decides, pin group by pin group, whether each output is driven from the core, forced to a fixed level, or floated. It knows three pin modes. In normal operation the core's values pass through. While the core reset input is low, the pins take fixed reset levels. While hold acknowledge is active, every pin that belongs to the shared bus floats so that another master can use it. Each pin group has its own output-enable signal, so a pad ring can drive the pin high, drive it low, or leave it undriven.

The block also handles the hold handshake with an external bus owner. It synchronizes the incoming request, grants it when the bus is between cycles, and holds the grant until the request is withdrawn. A request can be granted while the core is still in reset. Hold acknowledge takes precedence over the reset pin levels. A grant signal tells the core when it may begin a bus cycle. That signal stays low after reset is released for as long as a hold is outstanding, so processors that share one bus can be held off together at boot.

Top module: `bpc_bus_pinctl`

## Requirements
- R1: With core_rst_n low and hold_ack_o low, addr_oe_o, data_oe_o and stat_oe_o are 0, and every bit of tc_oe_o is 0, meaning the terminal-count pins act as inputs.
- R2: With core_rst_n low and hold_ack_o low, be_n_o is all ones, strb_n_o, wait_n_o, den_n_o and lock_n_o are 1, dack_n_o is all ones, and be_oe_o and ctl_oe_o are 1.
- R3: With core_rst_n low and hold_ack_o low, wr_o is 0 (read), last_n_o is 0, dir_o is 0 (receive), breq_o is 0 and fail_n_o is 0, all driven.
- R4: While hold_ack_o is 1, addr_oe_o, data_oe_o, be_oe_o, ctl_oe_o and stat_oe_o are 0. breq_o follows c_breq, fail_n_o is 1, dack_n_o is all ones, and tc_oe_o equals c_tc_is_out, where a bit value of 1 means output.
- R5: hold_req_i passes through a two-flop synchronizer. hold_ack_o rises on the third rising clock edge after hold_req_i goes high, provided a grant is allowed. It falls on the third rising edge after hold_req_i goes low.
- R6: While core_rst_n is high and cyc_busy_i is high, a pending request is not granted. The grant follows one clock edge after cyc_busy_i drops.
- R7: A request is granted while core_rst_n is low, whatever the value of cyc_busy_i. Once hold_ack_o is 1, asserting core_rst_n low leaves the pins in their hold states.
- R8: bus_grant_o is 1 only while core_rst_n is high, hold_ack_o is 0 and no synchronized request is pending. After reset is released with a hold granted, it stays 0 until the request is withdrawn and hold_ack_o falls.
- R9: With core_rst_n high and hold_ack_o low, every pin value equals its core input. addr_oe_o, be_oe_o, ctl_oe_o and stat_oe_o are 1, data_oe_o equals c_data_oe, and tc_oe_o equals c_tc_is_out.
- R10: The synchronous block reset rst clears the synchronizer and hold_ack_o at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block's flops |
| core_rst_n | input | 1 | Processor reset, active low; selects the reset pin states |
| hold_req_i | input | 1 | Asynchronous hold request from another bus master |
| cyc_busy_i | input | 1 | A core bus cycle is in progress |
| c_addr | input | ADDR_W | Core address (word address) |
| c_data | input | DATA_W | Core write data |
| c_data_oe | input | 1 | Core data bus drive request |
| c_be_n | input | BE_W | Core byte enables, active low |
| c_wr | input | 1 | Core direction, 1 = write |
| c_strb_n | input | 1 | Core address strobe, active low |
| c_wait_n | input | 1 | Core wait indication, active low |
| c_last_n | input | 1 | Core last-transfer marker, active low |
| c_dir | input | 1 | Core transceiver direction, 1 = transmit |
| c_den_n | input | 1 | Core data enable, active low |
| c_lock_n | input | 1 | Core locked-cycle marker, active low |
| c_stat | input | STAT_W | Core cycle status bits |
| c_breq | input | 1 | Core bus request to the external arbiter |
| c_fail_n | input | 1 | Core self-test failure, active low |
| c_dack_n | input | DMA_CH | Core DMA acknowledges, active low |
| c_tc | input | DMA_CH | Core terminal-count output values |
| c_tc_is_out | input | DMA_CH | Per channel, 1 = terminal-count pin is an output |
| addr_o | output | ADDR_W | Address pin values |
| addr_oe_o | output | 1 | Address group enable |
| data_o | output | DATA_W | Data pin values |
| data_oe_o | output | 1 | Data group enable |
| be_n_o | output | BE_W | Byte-enable pin values |
| be_oe_o | output | 1 | Byte-enable group enable |
| wr_o | output | 1 | Direction pin |
| strb_n_o | output | 1 | Address strobe pin |
| wait_n_o | output | 1 | Wait pin |
| last_n_o | output | 1 | Last-transfer pin |
| dir_o | output | 1 | Transceiver direction pin |
| den_n_o | output | 1 | Data enable pin |
| lock_n_o | output | 1 | Lock pin |
| ctl_oe_o | output | 1 | Control group enable |
| stat_o | output | STAT_W | Status pin values |
| stat_oe_o | output | 1 | Status group enable |
| breq_o | output | 1 | Bus request pin, always driven |
| fail_n_o | output | 1 | Failure pin, always driven |
| dack_n_o | output | DMA_CH | DMA acknowledge pins, always driven |
| tc_o | output | DMA_CH | Terminal-count pin values |
| tc_oe_o | output | DMA_CH | Per-pin terminal-count enables |
| hold_ack_o | output | 1 | Hold acknowledge |
| bus_grant_o | output | 1 | Core may start a bus cycle |

## Verification
The hardest state to reach is the overlap of the two precedence rules. That overlap covers three cases: a hold granted while the core is held in reset, reset released underneath that hold, and reset asserted underneath a hold that was granted during normal running. The stimulus reaches these states only through timed sequences. It raises the request during reset, counts the synchronizer edges, and releases or re-asserts core_rst_n while the request is still held. It then drops the request and watches the pins fall back to reset levels or to normal operation, and watches the bus grant return. A busy bus cycle blocks the grant in one test, and the block reset is pulsed under an active hold in another.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_RESET = 2'd1,
        PM_HOLD  = 2'd2
    } pin_mode_e;

    typedef struct packed {
        logic wr;
        logic strb_n;
        logic wait_n;
        logic last_n;
        logic dir;
        logic den_n;
        logic lock_n;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    // Fixed control levels while the core is in reset.
    localparam ctl_t CTL_IN_RESET = '{
        wr: 1'b0, strb_n: 1'b1, wait_n: 1'b1, last_n: 1'b0,
        dir: 1'b0, den_n: 1'b1, lock_n: 1'b1
    };

    // Hold acknowledge outranks reset; reset outranks normal running.
    function automatic pin_mode_e sel_mode(input logic rst_n, input logic ack);
        if (ack)    return PM_HOLD;
        if (!rst_n) return PM_RESET;
        return PM_RUN;
    endfunction

endpackage

// File: rtl/bpc_sync.sv
module bpc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/bpc_hold_ctl.sv
module bpc_hold_ctl (
    input  logic clk,
    input  logic rst,
    input  logic core_rst_n,
    input  logic req_sync,
    input  logic cyc_busy,
    output logic hold_ack,
    output logic bus_grant
);
    always_ff @(posedge clk) begin
        if (rst)
            hold_ack <= 1'b0;
        else if (!req_sync)
            hold_ack <= 1'b0;
        else if (!core_rst_n || !cyc_busy)
            hold_ack <= 1'b1;
    end

    assign bus_grant = core_rst_n & ~hold_ack & ~req_sync;

    // R5: acknowledge only rises on a synchronized request
    p_ack_needs_req_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_ack) |-> $past(req_sync));

    // R5: a withdrawn request drops the acknowledge on the next edge
    p_ack_release_r5: assert property (@(posedge clk) disable iff (rst)
        !req_sync |=> !hold_ack);

    // R6: no grant while a cycle is running outside reset
    p_busy_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        (core_rst_n && cyc_busy && !hold_ack) |=> !hold_ack);

    // R7: in reset a synchronized request is always granted
    p_grant_in_reset_r7: assert property (@(posedge clk) disable iff (rst)
        (!core_rst_n && req_sync) |=> hold_ack);
endmodule

// File: rtl/bpc_pin_mux.sv
module bpc_pin_mux
    import bpc_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int DATA_W = 32,
    parameter int BE_W   = 4,
    parameter int STAT_W = 3,
    parameter int DMA_CH = 4
) (
    input  pin_mode_e          mode,
    input  logic [ADDR_W-1:0]  c_addr,
    input  logic [DATA_W-1:0]  c_data,
    input  logic               c_data_oe,
    input  logic [BE_W-1:0]    c_be_n,
    input  ctl_t               c_ctl,
    input  logic [STAT_W-1:0]  c_stat,
    input  logic               c_breq,
    input  logic               c_fail_n,
    input  logic [DMA_CH-1:0]  c_dack_n,
    input  logic [DMA_CH-1:0]  c_tc,
    input  logic [DMA_CH-1:0]  c_tc_is_out,
    output logic [ADDR_W-1:0]  addr_o,
    output logic               addr_oe,
    output logic [DATA_W-1:0]  data_o,
    output logic               data_oe,
    output logic [BE_W-1:0]    be_n_o,
    output logic               be_oe,
    output ctl_t               ctl_o,
    output logic               ctl_oe,
    output logic [STAT_W-1:0]  stat_o,
    output logic               stat_oe,
    output logic               breq_o,
    output logic               fail_n_o,
    output logic [DMA_CH-1:0]  dack_n_o,
    output logic [DMA_CH-1:0]  tc_o,
    output logic [DMA_CH-1:0]  tc_oe
);
    // Value paths that never change with the mode.
    assign addr_o = c_addr;
    assign data_o = c_data;
    assign stat_o = c_stat;
    assign tc_o   = c_tc;

    always_comb begin
        addr_oe  = 1'b1;
        data_oe  = c_data_oe;
        be_n_o   = c_be_n;
        be_oe    = 1'b1;
        ctl_o    = c_ctl;
        ctl_oe   = 1'b1;
        stat_oe  = 1'b1;
        breq_o   = c_breq;
        fail_n_o = c_fail_n;
        dack_n_o = c_dack_n;
        unique case (mode)
            PM_RESET: begin
                addr_oe  = 1'b0;
                data_oe  = 1'b0;
                be_n_o   = '1;
                ctl_o    = CTL_IN_RESET;
                stat_oe  = 1'b0;
                breq_o   = 1'b0;
                fail_n_o = 1'b0;
                dack_n_o = '1;
            end
            PM_HOLD: begin
                addr_oe  = 1'b0;
                data_oe  = 1'b0;
                be_oe    = 1'b0;
                ctl_oe   = 1'b0;
                stat_oe  = 1'b0;
                fail_n_o = 1'b1;
                dack_n_o = '1;
            end
            default: ;
        endcase
    end

    // Each terminal-count pin: input mode in reset, otherwise its own direction.
    generate
        for (genvar ch = 0; ch < DMA_CH; ch++) begin : g_tc
            assign tc_oe[ch] = (mode == PM_RESET) ? 1'b0 : c_tc_is_out[ch];
        end
    endgenerate
endmodule

// File: rtl/bpc_bus_pinctl.sv
module bpc_bus_pinctl
    import bpc_pkg::*;
#(
    parameter int ADDR_W      = 30,
    parameter int DATA_W      = 32,
    parameter int STAT_W      = 3,
    parameter int DMA_CH      = 4,
    parameter int SYNC_STAGES = 2,
    parameter int BE_W        = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              core_rst_n,
    input  logic              hold_req_i,
    input  logic              cyc_busy_i,
    input  logic [ADDR_W-1:0] c_addr,
    input  logic [DATA_W-1:0] c_data,
    input  logic              c_data_oe,
    input  logic [BE_W-1:0]   c_be_n,
    input  logic              c_wr,
    input  logic              c_strb_n,
    input  logic              c_wait_n,
    input  logic              c_last_n,
    input  logic              c_dir,
    input  logic              c_den_n,
    input  logic              c_lock_n,
    input  logic [STAT_W-1:0] c_stat,
    input  logic              c_breq,
    input  logic              c_fail_n,
    input  logic [DMA_CH-1:0] c_dack_n,
    input  logic [DMA_CH-1:0] c_tc,
    input  logic [DMA_CH-1:0] c_tc_is_out,
    output logic [ADDR_W-1:0] addr_o,
    output logic              addr_oe_o,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o,
    output logic [BE_W-1:0]   be_n_o,
    output logic              be_oe_o,
    output logic              wr_o,
    output logic              strb_n_o,
    output logic              wait_n_o,
    output logic              last_n_o,
    output logic              dir_o,
    output logic              den_n_o,
    output logic              lock_n_o,
    output logic              ctl_oe_o,
    output logic [STAT_W-1:0] stat_o,
    output logic              stat_oe_o,
    output logic              breq_o,
    output logic              fail_n_o,
    output logic [DMA_CH-1:0] dack_n_o,
    output logic [DMA_CH-1:0] tc_o,
    output logic [DMA_CH-1:0] tc_oe_o,
    output logic              hold_ack_o,
    output logic              bus_grant_o
);
    logic      req_sync;
    pin_mode_e mode;
    ctl_t      core_ctl;
    ctl_t      pin_ctl;

    bpc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (hold_req_i),
        .q   (req_sync)
    );

    bpc_hold_ctl u_hold (
        .clk        (clk),
        .rst        (rst),
        .core_rst_n (core_rst_n),
        .req_sync   (req_sync),
        .cyc_busy   (cyc_busy_i),
        .hold_ack   (hold_ack_o),
        .bus_grant  (bus_grant_o)
    );

    assign mode = sel_mode(core_rst_n, hold_ack_o);

    assign core_ctl = '{wr: c_wr, strb_n: c_strb_n, wait_n: c_wait_n,
                        last_n: c_last_n, dir: c_dir, den_n: c_den_n,
                        lock_n: c_lock_n};

    bpc_pin_mux #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BE_W   (BE_W),
        .STAT_W (STAT_W),
        .DMA_CH (DMA_CH)
    ) u_mux (
        .mode        (mode),
        .c_addr      (c_addr),
        .c_data      (c_data),
        .c_data_oe   (c_data_oe),
        .c_be_n      (c_be_n),
        .c_ctl       (core_ctl),
        .c_stat      (c_stat),
        .c_breq      (c_breq),
        .c_fail_n    (c_fail_n),
        .c_dack_n    (c_dack_n),
        .c_tc        (c_tc),
        .c_tc_is_out (c_tc_is_out),
        .addr_o      (addr_o),
        .addr_oe     (addr_oe_o),
        .data_o      (data_o),
        .data_oe     (data_oe_o),
        .be_n_o      (be_n_o),
        .be_oe       (be_oe_o),
        .ctl_o       (pin_ctl),
        .ctl_oe      (ctl_oe_o),
        .stat_o      (stat_o),
        .stat_oe     (stat_oe_o),
        .breq_o      (breq_o),
        .fail_n_o    (fail_n_o),
        .dack_n_o    (dack_n_o),
        .tc_o        (tc_o),
        .tc_oe       (tc_oe_o)
    );

    assign wr_o     = pin_ctl.wr;
    assign strb_n_o = pin_ctl.strb_n;
    assign wait_n_o = pin_ctl.wait_n;
    assign last_n_o = pin_ctl.last_n;
    assign dir_o    = pin_ctl.dir;
    assign den_n_o  = pin_ctl.den_n;
    assign lock_n_o = pin_ctl.lock_n;

    // R4: the shared bus is released whenever hold is acknowledged
    p_hold_floats_r4: assert property (@(posedge clk) disable iff (rst)
        hold_ack_o |-> (!addr_oe_o && !data_oe_o && !be_oe_o && !ctl_oe_o
                        && !stat_oe_o && fail_n_o && (&dack_n_o)));

    // R3: reset levels on the control and failure pins
    p_reset_levels_r3: assert property (@(posedge clk) disable iff (rst)
        (!core_rst_n && !hold_ack_o) |-> (!wr_o && !last_n_o && !dir_o
                                          && !fail_n_o && !breq_o && ctl_oe_o));

    // R1: terminal-count pins are inputs during reset
    p_tc_input_r1: assert property (@(posedge clk) disable iff (rst)
        (!core_rst_n && !hold_ack_o) |-> (tc_oe_o == '0));

    // R8: the core never gets the bus while hold is acknowledged
    p_grant_excl_r8: assert property (@(posedge clk) disable iff (rst)
        hold_ack_o |-> !bus_grant_o);
endmodule

// File: tb/bpc_bus_pinctl_tb.sv
module bpc_bus_pinctl_tb;
    localparam int  ADDR_W  = 30;
    localparam int  DATA_W  = 32;
    localparam int  BE_W    = 4;
    localparam int  STAT_W  = 3;
    localparam int  DMA_CH  = 4;
    localparam time CLK_PER = 8ns;

    logic clk = 1'b0;
    logic rst, core_rst_n, hold_req_i, cyc_busy_i;
    logic [ADDR_W-1:0] c_addr;
    logic [DATA_W-1:0] c_data;
    logic c_data_oe;
    logic [BE_W-1:0] c_be_n;
    logic c_wr, c_strb_n, c_wait_n, c_last_n, c_dir, c_den_n, c_lock_n;
    logic [STAT_W-1:0] c_stat;
    logic c_breq, c_fail_n;
    logic [DMA_CH-1:0] c_dack_n, c_tc, c_tc_is_out;
    logic [ADDR_W-1:0] addr_o;
    logic addr_oe_o;
    logic [DATA_W-1:0] data_o;
    logic data_oe_o;
    logic [BE_W-1:0] be_n_o;
    logic be_oe_o, wr_o, strb_n_o, wait_n_o, last_n_o, dir_o, den_n_o, lock_n_o, ctl_oe_o;
    logic [STAT_W-1:0] stat_o;
    logic stat_oe_o, breq_o, fail_n_o;
    logic [DMA_CH-1:0] dack_n_o, tc_o, tc_oe_o;
    logic hold_ack_o, bus_grant_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    bpc_bus_pinctl u_dut (
        .clk(clk), .rst(rst), .core_rst_n(core_rst_n), .hold_req_i(hold_req_i),
        .cyc_busy_i(cyc_busy_i), .c_addr(c_addr), .c_data(c_data), .c_data_oe(c_data_oe),
        .c_be_n(c_be_n), .c_wr(c_wr), .c_strb_n(c_strb_n), .c_wait_n(c_wait_n),
        .c_last_n(c_last_n), .c_dir(c_dir), .c_den_n(c_den_n), .c_lock_n(c_lock_n),
        .c_stat(c_stat), .c_breq(c_breq), .c_fail_n(c_fail_n), .c_dack_n(c_dack_n),
        .c_tc(c_tc), .c_tc_is_out(c_tc_is_out),
        .addr_o(addr_o), .addr_oe_o(addr_oe_o), .data_o(data_o), .data_oe_o(data_oe_o),
        .be_n_o(be_n_o), .be_oe_o(be_oe_o), .wr_o(wr_o), .strb_n_o(strb_n_o),
        .wait_n_o(wait_n_o), .last_n_o(last_n_o), .dir_o(dir_o), .den_n_o(den_n_o),
        .lock_n_o(lock_n_o), .ctl_oe_o(ctl_oe_o), .stat_o(stat_o), .stat_oe_o(stat_oe_o),
        .breq_o(breq_o), .fail_n_o(fail_n_o), .dack_n_o(dack_n_o), .tc_o(tc_o),
        .tc_oe_o(tc_oe_o), .hold_ack_o(hold_ack_o), .bus_grant_o(bus_grant_o)
    );

    // Stimulus and expected pin states with no hold outstanding.
    typedef struct packed {
        logic       rstn;
        logic [3:0] be_n;
        logic [3:0] tc_out;
        logic       doe;
        logic       fail_n;
        logic [3:0] e_be_n;
        logic [3:0] e_tc_oe;
        logic       e_doe;
        logic       e_fail_n;
        logic       e_addr_oe;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 4'hA, 4'h5, 1'b1, 1'b1, 4'hA, 4'h5, 1'b1, 1'b1, 1'b1},
        '{1'b1, 4'h3, 4'hC, 1'b0, 1'b0, 4'h3, 4'hC, 1'b0, 1'b0, 1'b1},
        '{1'b0, 4'h0, 4'hF, 1'b1, 1'b1, 4'hF, 4'h0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 4'h5, 4'h3, 1'b0, 1'b0, 4'hF, 4'h0, 1'b0, 1'b0, 1'b0},
        '{1'b1, 4'hF, 4'h0, 1'b1, 1'b0, 4'hF, 4'h0, 1'b1, 1'b0, 1'b1},
        '{1'b1, 4'h0, 4'hF, 1'b0, 1'b1, 4'h0, 4'hF, 1'b0, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [6:0] ctl_bits();
        return {wr_o, strb_n_o, wait_n_o, last_n_o, dir_o, den_n_o, lock_n_o};
    endfunction

    task automatic chk_reset_pins(input string req);
        chk(req, "R1 float oe {addr,data,stat,tc}",
            {addr_oe_o, data_oe_o, stat_oe_o, tc_oe_o}, 7'b000_0000);
        chk(req, "R2 high pins", {be_n_o, dack_n_o, be_oe_o, ctl_oe_o}, 10'h3FF);
        chk(req, "R3 ctl levels", ctl_bits(), 7'b0110011);
        chk(req, "R3 breq/fail", {breq_o, fail_n_o}, 2'b00);
    endtask

    task automatic chk_hold_pins(input string req);
        chk(req, "R4 float oe", {addr_oe_o, data_oe_o, be_oe_o, ctl_oe_o, stat_oe_o}, 5'b0);
        chk(req, "R4 breq follows core", breq_o, c_breq);
        chk(req, "R4 fail/dack high", {fail_n_o, dack_n_o}, 5'h1F);
        chk(req, "R4 tc oe follows dir", tc_oe_o, c_tc_is_out);
    endtask

    initial begin
        rst = 1'b1; core_rst_n = 1'b0; hold_req_i = 1'b0; cyc_busy_i = 1'b0;
        c_addr = 30'h1234567; c_data = 32'hCAFE_F00D; c_data_oe = 1'b1;
        c_be_n = 4'h0; {c_wr, c_strb_n, c_wait_n, c_last_n, c_dir, c_den_n, c_lock_n} = 7'b1001100;
        c_stat = 3'b101; c_breq = 1'b1; c_fail_n = 1'b1;
        c_dack_n = 4'h6; c_tc = 4'h9; c_tc_is_out = 4'hA;
        edges(3);
        rst = 1'b0;
        edges(1);

        // Reset state of the block, core held in reset
        chk("R10", "hold_ack after block reset", hold_ack_o, 1'b0);
        chk("R8", "no grant in reset", bus_grant_o, 1'b0);
        chk_reset_pins("R1");

        // Table walk with no hold outstanding
        foreach (VECS[k]) begin
            core_rst_n  = VECS[k].rstn;
            c_be_n      = VECS[k].be_n;
            c_tc_is_out = VECS[k].tc_out;
            c_data_oe   = VECS[k].doe;
            c_fail_n    = VECS[k].fail_n;
            #1;
            chk(VECS[k].rstn ? "R9" : "R2", "be_n", be_n_o, VECS[k].e_be_n);
            chk(VECS[k].rstn ? "R9" : "R1", "tc_oe", tc_oe_o, VECS[k].e_tc_oe);
            chk(VECS[k].rstn ? "R9" : "R1", "data_oe", data_oe_o, VECS[k].e_doe);
            chk(VECS[k].rstn ? "R9" : "R3", "fail_n", fail_n_o, VECS[k].e_fail_n);
            chk(VECS[k].rstn ? "R9" : "R1", "addr_oe", addr_oe_o, VECS[k].e_addr_oe);
            edges(1);
        end

        // Normal running: full pass-through
        core_rst_n = 1'b1; c_tc_is_out = 4'hA; c_data_oe = 1'b1; c_fail_n = 1'b1;
        #1;
        chk("R9", "addr", addr_o, c_addr);
        chk("R9", "data", data_o, c_data);
        chk("R9", "ctl", ctl_bits(), 7'b1001100);
        chk("R9", "stat/breq/dack/tc", {stat_o, breq_o, dack_n_o, tc_o}, {3'b101, 1'b1, 4'h6, 4'h9});
        chk("R8", "grant when idle", bus_grant_o, 1'b1);

        // Hold requested while the core is in reset, busy ignored
        core_rst_n = 1'b0; cyc_busy_i = 1'b1;
        edges(1);
        hold_req_i = 1'b1;
        edges(2);
        chk("R5", "ack not yet after two edges", hold_ack_o, 1'b0);
        edges(1);
        chk("R7", "ack granted in reset", hold_ack_o, 1'b1);
        chk_hold_pins("R7");
        // Reset released under hold: bus stays blocked
        core_rst_n = 1'b1;
        edges(4);
        chk("R8", "no grant after reset release with hold", bus_grant_o, 1'b0);
        chk_hold_pins("R4");
        cyc_busy_i = 1'b0;
        hold_req_i = 1'b0;
        edges(2);
        chk("R5", "ack held two edges after drop", hold_ack_o, 1'b1);
        edges(1);
        chk("R5", "ack falls on third edge", hold_ack_o, 1'b0);
        chk("R8", "grant returns", bus_grant_o, 1'b1);
        chk("R9", "pins back to core", {addr_oe_o, ctl_oe_o, ctl_bits()}, {2'b11, 7'b1001100});

        // Request during a busy cycle outside reset
        cyc_busy_i = 1'b1;
        hold_req_i = 1'b1;
        edges(6);
        chk("R6", "no ack while busy", hold_ack_o, 1'b0);
        chk("R8", "no grant with request pending", bus_grant_o, 1'b0);
        cyc_busy_i = 1'b0;
        edges(1);
        chk("R6", "ack one edge after busy drops", hold_ack_o, 1'b1);
        c_breq = 1'b0; c_tc_is_out = 4'h3;
        #1;
        chk_hold_pins("R4");

        // Reset asserted under an existing hold keeps hold states
        core_rst_n = 1'b0;
        #1;
        chk_hold_pins("R7");
        chk("R7", "wr floats", ctl_oe_o, 1'b0);
        hold_req_i = 1'b0;
        edges(3);
        chk("R7", "ack released in reset", hold_ack_o, 1'b0);
        chk_reset_pins("R3");

        // Block reset under an active hold
        hold_req_i = 1'b1;
        edges(3);
        chk("R7", "ack again in reset", hold_ack_o, 1'b1);
        rst = 1'b1;
        edges(1);
        chk("R10", "block reset clears ack", hold_ack_o, 1'b0);
        rst = 1'b0;
        edges(2);
        chk("R10", "synchronizer refills from empty", hold_ack_o, 1'b0);
        edges(1);
        chk("R5", "ack after refill", hold_ack_o, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PER * 150000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule